// File: doc/BRIEF.md
# Block Write-Protect Arbiter

This block decides, for each program or erase request aimed at a flash block, whether the request may go ahead. It keeps one software lock bit per block in a small register file that is written and read back through a simple register port. It also takes two active-low hardware protect inputs. One covers the top boot region, which is the highest `TOP_BLOCKS` blocks. The other covers every block below that region.

The two inputs are independent of each other. Each is OR-combined with the lock bits of its own region. A block is protected when its region's pin is low or its lock bit is set. The pin levels and lock bits are taken in the cycle the request is presented. One cycle later, the block gives exactly one single-cycle pulse: `grant` passes the request on to the write engine, and `deny_err` reports a refused request. A pin that changes after that cycle does not alter the decision.

The lock register always reads back what software last wrote. It can therefore show a block as unlocked while the pin for its region still protects it.

Top module: `blk_wp_arbiter`

## Requirements
- R1: After reset every lock bit reads back as 1 (locked), and neither `grant` nor `deny_err` is high.
- R2: A request to a top-region block (index >= NUM_BLOCKS-TOP_BLOCKS) while `top_lock_n` is 0 is denied, whatever its lock bit holds.
- R3: A request to a block below the top region while `wr_prot_n` is 0 is denied, whatever its lock bit holds.
- R4: When the pin for the target's region is 1, a request is denied if the block's lock bit is 1 and granted if it is 0.
- R5: A write of 0 to a lock bit while its region's pin is 0 is accepted and reads back as 0 on `reg_rdata`, yet requests to that block stay denied.
- R6: `top_lock_n` has no effect on requests to blocks below the top region, and `wr_prot_n` has no effect on requests to top-region blocks.
- R7: The pin levels are taken in the cycle `req_valid` is high. A pin change in the following cycle does not change the decision for that request.
- R8: Each cycle with `req_valid` high is followed, one cycle later, by exactly one pulse on either `grant` or `deny_err`. With no request, both stay low.
- R9: A lock write in the same cycle as a request to the same block takes effect for later requests only. The request in that cycle is decided on the lock value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Lock register write strobe |
| reg_addr | input | IDX_W | Lock register index for both write and readback |
| reg_wdata | input | 1 | Lock bit value to write (1 = locked) |
| reg_rdata | output | 1 | Lock bit stored at `reg_addr` |
| req_valid | input | 1 | Program/erase request strobe |
| req_blk | input | IDX_W | Target block of the request |
| top_lock_n | input | 1 | Active-low protect for the top boot region |
| wr_prot_n | input | 1 | Active-low protect for all other blocks |
| grant | output | 1 | One-cycle pulse: request allowed |
| deny_err | output | 1 | One-cycle pulse: request refused |

## Verification
The hardest case to reach from the ports is a lock register that reads back as unlocked while its pin still protects the block. The bench sets up this case by driving the region's pin low before clearing the lock bit. It reads the bit back, then issues a request with the pin still low. A table walks every combination of pin level and lock bit for one block in each region and checks the outcome against the OR rule.

Directed sequences then cover three timing cases. First, the pins are toggled in the cycle right after a request, to show that sampling happens at the request. Second, a lock write is placed in the same cycle as a request. Third, idle cycles are checked for stray pulses.

// File: rtl/blk_wp_arbiter.sv
module blk_wp_arbiter #(
  parameter int NUM_BLOCKS = 8,
  parameter int TOP_BLOCKS = 1,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic             reg_wdata,
  output logic             reg_rdata,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_blk,
  input  logic             top_lock_n,
  input  logic             wr_prot_n,
  output logic             grant,
  output logic             deny_err
);
  localparam int TOP_BASE = NUM_BLOCKS - TOP_BLOCKS;

  logic [NUM_BLOCKS-1:0] lock_q;
  logic req_top, req_lock, req_pin_ok, blocked;
  logic grant_q, deny_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      lock_q <= '1;
    else if (reg_wr) lock_q[reg_addr] <= reg_wdata;
  end

  assign reg_rdata  = lock_q[reg_addr];
  assign req_top    = int'(req_blk) >= TOP_BASE;
  assign req_lock   = lock_q[req_blk];
  assign req_pin_ok = req_top ? top_lock_n : wr_prot_n;
  assign blocked    = !req_pin_ok || req_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= req_valid && !blocked;
      deny_q  <= req_valid && blocked;
    end
  end

  assign grant    = grant_q;
  assign deny_err = deny_q;

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant != deny_err)); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant && !deny_err)); // R8
  AST_TOP_PIN_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_top && !top_lock_n) |=> deny_err); // R2
  AST_LOW_PIN_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_top && !wr_prot_n) |=> deny_err); // R3
  AST_LOCKED_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_lock) |=> deny_err); // R4
  AST_OPEN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_pin_ok && !req_lock) |=> grant); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!grant && !deny_err)); // R1
endmodule

// File: tb/tb_blk_wp_arbiter.sv
module tb_blk_wp_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_wdata = 1'b0, req_valid = 1'b0;
  logic [IW-1:0] reg_addr = '0, req_blk = '0;
  logic top_lock_n = 1'b1, wr_prot_n = 1'b1;
  logic reg_rdata, grant, deny_err;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_wp_arbiter #(.NUM_BLOCKS(NB), .TOP_BLOCKS(1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_blk(req_blk), .top_lock_n(top_lock_n), .wr_prot_n(wr_prot_n),
    .grant(grant), .deny_err(deny_err));

  // {blk[2:0], top_lock_n, wr_prot_n, lock, expected grant}
  localparam logic [6:0] VEC [16] = '{
    7'b010_0000, 7'b010_0010, 7'b010_0101, 7'b010_0110,
    7'b010_1000, 7'b010_1010, 7'b010_1101, 7'b010_1110,
    7'b111_0000, 7'b111_0010, 7'b111_0100, 7'b111_0110,
    7'b111_1001, 7'b111_1010, 7'b111_1101, 7'b111_1110};

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic write_lock(input logic [IW-1:0] b, input logic v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = b; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic request(input logic [IW-1:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_blk = b;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int b = 0; b < NB; b++) begin
      reg_addr = IW'(b); #1;
      check("R1 lock reads locked", reg_rdata, 1'b1);
    end
    check("R1 grant low", grant, 1'b0);
    check("R1 deny low", deny_err, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R5 R6: table walk over pin and lock combinations
    for (int i = 0; i < 16; i++) begin
      logic [IW-1:0] b;
      logic exp;
      b = VEC[i][6:4];
      exp = VEC[i][0];
      @(negedge clk);
      top_lock_n = VEC[i][3]; wr_prot_n = VEC[i][2];
      write_lock(b, VEC[i][1]);
      reg_addr = b; #1;
      check("R5 readback follows write", reg_rdata, VEC[i][1]);
      request(b);
      if (b == 3'd7) begin
        check("R2/R4/R6 top grant", grant, exp);
        check("R2/R4/R6 top deny", deny_err, !exp);
      end else begin
        check("R3/R4/R6 low grant", grant, exp);
        check("R3/R4/R6 low deny", deny_err, !exp);
      end
    end

    // R5: cleared under low pin, reads 0, still denied
    @(negedge clk); wr_prot_n = 1'b0; top_lock_n = 1'b1;
    write_lock(3'd4, 1'b0);
    reg_addr = 3'd4; #1;
    check("R5 cleared bit reads 0", reg_rdata, 1'b0);
    request(3'd4);
    check("R5 still denied", deny_err, 1'b1);

    // R7: pin falls just after request edge, decision stays grant
    @(negedge clk); wr_prot_n = 1'b1; top_lock_n = 1'b1;
    write_lock(3'd7, 1'b0);
    @(negedge clk); req_valid = 1'b1; req_blk = 3'd7;
    @(posedge clk); #1; top_lock_n = 1'b0; req_valid = 1'b0;
    check("R7 grant kept after pin drop", grant, 1'b1);
    // R7: pin rises just after request edge, decision stays deny
    @(negedge clk); req_valid = 1'b1; req_blk = 3'd7;
    @(posedge clk); #1; top_lock_n = 1'b1; req_valid = 1'b0;
    check("R7 deny kept after pin rise", deny_err, 1'b1);

    // R8: idle cycle gives no pulse
    @(posedge clk); #1;
    check("R8 idle grant", grant, 1'b0);
    check("R8 idle deny", deny_err, 1'b0);

    // R9: same-cycle write uses old lock value
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 1'b0;
    req_valid = 1'b1; req_blk = 3'd1;
    @(posedge clk); #1;
    reg_wr = 1'b0; req_valid = 1'b0;
    check("R9 same-cycle request uses old lock", deny_err, 1'b1);
    request(3'd1);
    check("R9 next request sees new lock", grant, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule